// File: doc/BRIEF.md
# Scaled Pixel Serializer with Attributes

This block sits between the screen fetch logic and the palette of a raster display engine. On each cycle of the pixel clock it issues one 4-bit logical colour for one of the 640 horizontal slots of a scan line. Screen bytes come in one at a time from the fetch side. Each byte is tagged as either bitmap data or attribute data. The block holds at most one bitmap byte in waiting. It unpacks the current byte most significant pixel first, at 1, 2 or 4 bits per pixel, and repeats each pixel 1, 2, 3 or 4 times to fill the line.

In attribute mode the bitmap is read at one bit per pixel and the colours come from attribute bytes. Attribute bytes are fetched in the spare slot before each character column and are stored only on the first pixel row of a character. The remaining seven rows reuse the stored bytes. In the packed variant, one attribute byte serves two adjacent columns, one nibble each. The tripled-pixel mode fits 26 columns and leaves 16 blank slots, placed at the start of the line by default.

Top module: `pix_serializer`

## Requirements
- R1: After reset, `pix_out` is 0 and `underflow` is 0.
- R2: With attribute mode off, a bitmap byte yields 8, 4 or 2 pixels for `cfg_depth` codes 0, 1 and 2 (1, 2 and 4 bits per pixel). Pixels are taken from the most significant end of the byte and zero-extended to 4 bits. Each pixel is held for `cfg_scale`+1 consecutive slots, so `cfg_scale` codes 0 to 3 select scaling by 1 to 4.
- R3: The output is registered. The colour for a clock edge with `pix_en` high appears after that edge. After an edge with `pix_en` low, or with `line_start` high, `pix_out` is 0.
- R4: When `cfg_scale` is 2 (triple), the first 16 slots after `line_start` output 0 and consume no byte.
- R5: Only one bitmap byte waits at a time. It is consumed exactly when the byte in use has emitted all of its slots, so bytes are shown back to back in arrival order.
- R6: If no bitmap byte is waiting when a new one is needed, that slot outputs 0 with `underflow` high. The pixel position does not advance, and the load is retried on the next slot.
- R7: With `cfg_attr_en` set, the bitmap is read at 1 bit per pixel and the first 8 slots of the line are blank. A set bit shows the upper nibble of the column's attribute and a clear bit shows the lower nibble.
- R8: Attribute bytes are stored in arrival order only when `row_line` is 0. On any other row they are ignored, and the stored bytes keep colouring the columns.
- R9: With `cfg_attr_packed` also set, stored attribute k colours column 2k from its upper nibble and column 2k+1 from its lower nibble. In each nibble, bits [3:2] are the foreground index and bits [1:0] the background index, and the output is {2'b00, index}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, one slot per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Restarts the slot, column and attribute positions for a new line |
| pix_en | input | 1 | High during the active slots of the line |
| row_line | input | 3 | Pixel row inside the current character row |
| byte_valid | input | 1 | A fetched byte is present on `byte_data` |
| byte_is_attr | input | 1 | The present byte is an attribute (1) or bitmap (0) |
| byte_data | input | 8 | Fetched screen byte |
| cfg_scale | input | 2 | Pixel replication: 0 single, 1 double, 2 triple, 3 quadruple |
| cfg_depth | input | 2 | Bits per pixel: 0 one, 1 two, 2 four |
| cfg_attr_en | input | 1 | Attribute colouring mode |
| cfg_attr_packed | input | 1 | One attribute byte shared by two columns |
| pix_out | output | 4 | Logical colour of the current slot |
| underflow | output | 1 | The slot needed a byte that had not arrived |

## Verification
The bench builds the block with its default parameters: 640 slots, 80 columns, a 40-entry attribute store and blank padding at the start of the line. These defaults make every scale and depth combination reachable with full-width lines. They also cover the triple mode with its 16 blank lead slots and both attribute layouts at double width, where all 40 store entries and the half-column tail of the line are used. The starvation case is driven directly by holding back the first byte of a line.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {SCL_X1, SCL_X2, SCL_X3, SCL_X4} scale_e;
   typedef enum logic [1:0] {BPP_1, BPP_2, BPP_4, BPP_4B} depth_e;

   // bits per pixel for a depth code
   function automatic logic [2:0] bpp_of(input depth_e d, input logic force_one);
      if (force_one) return 3'd1;
      case (d)
         BPP_1:   return 3'd1;
         BPP_2:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction
endpackage

// File: rtl/pixser_slot_ctrl.sv
module pixser_slot_ctrl
   import pixser_pkg::*;
#(
   parameter int LINE_SLOTS = 640,
   parameter int PAD3       = 16,
   parameter int ATTR_LEAD  = 8,
   parameter bit PAD_LEAD   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_start,
   input  logic       pix_en,
   input  logic [1:0] scale,
   input  logic       attr_en,
   output logic       blank
);
   localparam int SW = $clog2(LINE_SLOTS + 1);
   localparam logic [SW-1:0] LAST   = SW'(LINE_SLOTS);
   localparam logic [SW-1:0] PADV   = SW'(PAD3);
   localparam logic [SW-1:0] ALEADV = SW'(ATTR_LEAD);
   localparam logic [SW-1:0] TAILV  = SW'(LINE_SLOTS - PAD3);

   logic [SW-1:0] slot;
   logic [SW-1:0] lead;
   logic          triple;

   assign triple = (scale_e'(scale) == SCL_X3);

   always_ff @(posedge clk) begin
      if (!rst_n)                    slot <= LAST;
      else if (line_start)           slot <= '0;
      else if (pix_en && slot < LAST) slot <= slot + 1'b1;
   end

   generate
      if (PAD_LEAD) begin : g_pad_lead
         assign lead  = (attr_en ? ALEADV : '0) + (triple ? PADV : '0);
         assign blank = (slot < lead) || (slot >= LAST);
      end else begin : g_pad_tail
         assign lead  = attr_en ? ALEADV : '0;
         assign blank = (slot < lead) || (slot >= LAST) || (triple && slot >= TAILV);
      end
   endgenerate
endmodule

// File: rtl/pixser_shifter.sv
module pixser_shifter
   import pixser_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              adv,
   input  logic              wr,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [1:0]        scale,
   input  logic [1:0]        depth,
   input  logic              force_one,
   output logic              take,
   output logic              miss,
   output logic [3:0]        pix_bits
);
   logic [BYTE_W-1:0] pend, cur, src;
   logic              pend_full;
   logic [2:0]        pidx, pix_last, bpp;
   logic [1:0]        rep;
   logic              at_start;

   assign bpp      = bpp_of(depth_e'(depth), force_one);
   assign pix_last = (bpp == 3'd1) ? 3'd7 : (bpp == 3'd2) ? 3'd3 : 3'd1;
   assign at_start = (pidx == 3'd0) && (rep == 2'd0);
   assign take     = adv && at_start && pend_full;
   assign miss     = adv && at_start && !pend_full;
   assign src      = at_start ? pend : cur;
   assign pix_bits = src[BYTE_W-1 -: 4];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend      <= '0;
         pend_full <= 1'b0;
         cur       <= '0;
         pidx      <= '0;
         rep       <= '0;
      end else begin
         if (wr) begin
            pend      <= wdata;
            pend_full <= 1'b1;
         end else if (take) begin
            pend_full <= 1'b0;
         end
         if (line_start) begin
            pidx <= '0;
            rep  <= '0;
         end else if (adv && !miss) begin
            if (rep == scale) begin
               rep  <= '0;
               cur  <= BYTE_W'(src << bpp);
               pidx <= (pidx == pix_last) ? 3'd0 : pidx + 3'd1;
            end else begin
               rep <= rep + 2'd1;
               cur <= src;
            end
         end
      end
   end
endmodule

// File: rtl/pixser_attr_buf.sv
module pixser_attr_buf
   import pixser_pkg::*;
#(
   parameter int DEPTH = 40,
   parameter int AW    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [BYTE_W-1:0] rdata
);
   localparam logic [AW-1:0] DV = AW'(DEPTH);

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [AW-1:0]     widx;

   always_ff @(posedge clk) begin
      if (!rst_n)          widx <= '0;
      else if (line_start) widx <= '0;
      else if (wr_en && widx < DV) widx <= widx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && widx < DV) mem[widx[AW-2:0]] <= wdata;
   end

   assign rdata = (raddr < DV) ? mem[raddr[AW-2:0]] : '0;
endmodule

// File: rtl/pix_serializer.sv
module pix_serializer
   import pixser_pkg::*;
#(
   parameter int LINE_SLOTS = 640,
   parameter int MAX_COLS   = 80,
   parameter int ATTR_COLS  = 40,
   parameter int ROW_W      = 3,
   parameter bit PAD_LEAD   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              pix_en,
   input  logic [ROW_W-1:0]  row_line,
   input  logic              byte_valid,
   input  logic              byte_is_attr,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [1:0]        cfg_scale,
   input  logic [1:0]        cfg_depth,
   input  logic              cfg_attr_en,
   input  logic              cfg_attr_packed,
   output logic [3:0]        pix_out,
   output logic              underflow
);
   localparam int CW = $clog2(MAX_COLS + 1);
   localparam int AW = $clog2(ATTR_COLS) + 1;
   localparam logic [CW-1:0] CMAX = CW'(MAX_COLS);

   generate
      if (ATTR_COLS < 2 || ATTR_COLS > MAX_COLS) begin : g_bad_attr
         $error("ATTR_COLS must lie in 2..MAX_COLS");
      end
      if (LINE_SLOTS < 64) begin : g_bad_line
         $error("LINE_SLOTS too small");
      end
   endgenerate

   logic              blank, adv, take, miss, attr_wr;
   logic [3:0]        pix_bits, colour, nib;
   logic [CW-1:0]     col, col_idx;
   logic [AW-1:0]     raddr;
   logic [BYTE_W-1:0] rdata, a_cur, att;
   logic              par_cur, par;

   assign adv     = pix_en && !line_start && !blank;
   assign attr_wr = byte_valid && byte_is_attr && cfg_attr_en && (row_line == '0);

   pixser_slot_ctrl #(
      .LINE_SLOTS(LINE_SLOTS), .PAD3(16), .ATTR_LEAD(8), .PAD_LEAD(PAD_LEAD)
   ) u_slot (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_en(pix_en),
      .scale(cfg_scale), .attr_en(cfg_attr_en), .blank(blank)
   );

   pixser_shifter u_shift (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .adv(adv),
      .wr(byte_valid && !byte_is_attr), .wdata(byte_data),
      .scale(cfg_scale), .depth(cfg_depth), .force_one(cfg_attr_en),
      .take(take), .miss(miss), .pix_bits(pix_bits)
   );

   pixser_attr_buf #(.DEPTH(ATTR_COLS), .AW(AW)) u_attr (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .wr_en(attr_wr),
      .wdata(byte_data), .raddr(raddr), .rdata(rdata)
   );

   // column of the byte being loaded
   always_ff @(posedge clk) begin
      if (!rst_n)                    col <= '0;
      else if (line_start)           col <= '0;
      else if (take && col < CMAX)   col <= col + 1'b1;
   end

   assign col_idx = cfg_attr_packed ? (col >> 1) : col;
   assign raddr   = AW'(col_idx);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         a_cur   <= '0;
         par_cur <= 1'b0;
      end else if (take) begin
         a_cur   <= rdata;
         par_cur <= col[0];
      end
   end

   assign att = take ? rdata  : a_cur;
   assign par = take ? col[0] : par_cur;
   assign nib = par ? att[3:0] : att[7:4];

   always_comb begin
      if (cfg_attr_en) begin
         if (cfg_attr_packed) colour = {2'b00, pix_bits[3] ? nib[3:2] : nib[1:0]};
         else                 colour = pix_bits[3] ? att[7:4] : att[3:0];
      end else begin
         case (depth_e'(cfg_depth))
            BPP_1:   colour = {3'b000, pix_bits[3]};
            BPP_2:   colour = {2'b00, pix_bits[3:2]};
            default: colour = pix_bits;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_out   <= '0;
         underflow <= 1'b0;
      end else begin
         pix_out   <= (adv && !miss) ? colour : 4'd0;
         underflow <= miss;
      end
   end
endmodule

// File: rtl/pixser_chk.sv
module pixser_chk #(
   parameter int LINE_SLOTS = 640
) (
   input logic       clk,
   input logic       rst_n,
   input logic       line_start,
   input logic       pix_en,
   input logic [1:0] cfg_scale,
   input logic       cfg_attr_en,
   input logic [3:0] pix_out,
   input logic       underflow
);
   localparam int SW = $clog2(LINE_SLOTS + 1);
   logic [SW-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n)                                   seen <= SW'(LINE_SLOTS);
      else if (line_start)                          seen <= '0;
      else if (pix_en && seen < SW'(LINE_SLOTS))    seen <= seen + 1'b1;
   end

   // R3
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> (pix_out == 4'd0));
   // R3
   start_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (pix_out == 4'd0 && !underflow));
   // R6
   miss_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |-> (pix_out == 4'd0));
   // R4
   pad3_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !line_start && cfg_scale == 2'd2 && seen < SW'(16)) |=> (pix_out == 4'd0));
   // R7
   attr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !line_start && cfg_attr_en && seen < SW'(8)) |=> (pix_out == 4'd0 && !underflow));
endmodule

bind pix_serializer pixser_chk #(.LINE_SLOTS(LINE_SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_en(pix_en),
   .cfg_scale(cfg_scale), .cfg_attr_en(cfg_attr_en),
   .pix_out(pix_out), .underflow(underflow)
);

// File: tb/pix_serializer_test.sv
module pix_serializer_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_start = 1'b0, pix_en = 1'b0;
   logic [2:0] row_line = '0;
   logic       byte_valid = 1'b0, byte_is_attr = 1'b0;
   logic [7:0] byte_data = '0;
   logic [1:0] cfg_scale = '0, cfg_depth = '0;
   logic       cfg_attr_en = 1'b0, cfg_attr_packed = 1'b0;
   logic [3:0] pix_out;
   logic       underflow;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0] bm [80];
   logic [7:0] asend [40];
   logic [7:0] abuf [40];

   always #5 clk = ~clk;

   pix_serializer uut (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_en(pix_en),
      .row_line(row_line), .byte_valid(byte_valid), .byte_is_attr(byte_is_attr),
      .byte_data(byte_data), .cfg_scale(cfg_scale), .cfg_depth(cfg_depth),
      .cfg_attr_en(cfg_attr_en), .cfg_attr_packed(cfg_attr_packed),
      .pix_out(pix_out), .underflow(underflow)
   );

   task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp,
                        input logic uact, input logic uexp);
      checks++;
      if (act !== exp || uact !== uexp) begin
         errors++;
         $display("FAIL %s: pix_out=%0h underflow=%0b expected pix_out=%0h underflow=%0b (t=%0t)",
                  tag, act, uact, exp, uexp, $time);
      end
   endtask

   function automatic logic [3:0] exp_pix(input int dp, input bit at, input bit pk,
                                          input logic [7:0] b, input int pix,
                                          input logic [7:0] a, input int col);
      logic bitv;
      logic [3:0] nb;
      if (at) begin
         bitv = b[7-pix];
         if (pk) begin
            nb = (col % 2 == 1) ? a[3:0] : a[7:4];
            return {2'b00, bitv ? nb[3:2] : nb[1:0]};
         end
         return bitv ? a[7:4] : a[3:0];
      end
      case (dp)
         0:       return {3'b000, b[7-pix]};
         1:       return {2'b00, b[7-2*pix -: 2]};
         default: return b[7-4*pix -: 4];
      endcase
   endfunction

   task automatic run_line(input int sc, input int dp, input bit at, input bit pk, input int row);
      int ppb, rp, S, B;
      string tag;
      ppb = at ? 8 : (8 >> dp);
      rp  = sc + 1;
      S   = ppb * rp;
      B   = (at ? 8 : 0) + (sc == 2 ? 16 : 0);
      if (at) tag = pk ? "R9" : ((row != 0) ? "R8" : "R7");
      else    tag = (sc == 2) ? "R4" : "R2 R5";
      if (at && row == 0) begin
         for (int k = 0; k < 40; k++) begin
            if (!pk) abuf[k] = asend[k];
            else if (k < 20) abuf[k] = asend[k];
         end
      end
      cfg_scale = 2'(sc); cfg_depth = 2'(dp);
      cfg_attr_en = at; cfg_attr_packed = pk; row_line = 3'(row);
      for (int t = -1; t <= 640; t++) begin
         @(negedge clk);
         if (t >= 1) begin
            int s;
            s = t - 1;
            if (s < B) check(tag, pix_out, 4'd0, underflow, 1'b0);
            else begin
               int k, w, c;
               k = (s - B) / S;
               w = (s - B) % S;
               c = pk ? k / 2 : k;
               check(tag, pix_out, exp_pix(dp, at, pk, bm[k], w / rp, abuf[c], k),
                     underflow, 1'b0);
            end
         end
         line_start = (t == -1);
         pix_en     = (t >= 0 && t <= 639);
         byte_valid = 1'b0; byte_is_attr = 1'b0; byte_data = '0;
         if (t + 1 >= B && t + 1 <= 639 && (t + 1 - B) % S == 0) begin
            byte_valid = 1'b1; byte_data = bm[(t + 1 - B) / S];
         end else if (at && t + 2 >= B && t + 2 <= 639 && (t + 2 - B) % S == 0) begin
            int k;
            k = (t + 2 - B) / S;
            if (!pk && k < 40) begin
               byte_valid = 1'b1; byte_is_attr = 1'b1; byte_data = asend[k];
            end else if (pk && k % 2 == 0) begin
               byte_valid = 1'b1; byte_is_attr = 1'b1; byte_data = asend[k / 2];
            end
         end
      end
      @(negedge clk);
      check("R3 idle", pix_out, 4'd0, underflow, 1'b0);
   endtask

   task automatic fill_random();
      for (int k = 0; k < 80; k++) bm[k] = 8'($urandom);
      for (int k = 0; k < 40; k++) asend[k] = 8'($urandom);
   endtask

   initial begin
      void'($urandom(32'd1977));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", pix_out, 4'd0, underflow, 1'b0);

      // directed: every scale/depth
      fill_random(); run_line(0, 0, 0, 0, 0);
      fill_random(); run_line(1, 1, 0, 0, 0);
      fill_random(); run_line(3, 2, 0, 0, 0);
      bm[0] = 8'hFF; bm[25] = 8'h81;
      run_line(2, 0, 0, 0, 0);          // R4 triple with lead pad
      // R7 then R8: store on row 0, ignore on row 1
      fill_random(); run_line(1, 0, 1, 0, 0);
      fill_random(); run_line(1, 0, 1, 0, 1);
      // R9 packed store then reuse on later row
      fill_random(); run_line(1, 0, 1, 1, 0);
      fill_random(); run_line(1, 0, 1, 1, 3);
      // random configurations
      for (int i = 0; i < 6; i++) begin
         int sc, dp;
         sc = int'($urandom % 4);
         dp = int'($urandom % 3);
         fill_random();
         run_line(sc, dp, 0, 0, 0);
      end

      // R6 starvation: first byte arrives late
      cfg_scale = 2'd0; cfg_depth = 2'd0; cfg_attr_en = 1'b0; cfg_attr_packed = 1'b0;
      for (int t = -1; t <= 15; t++) begin
         @(negedge clk);
         if (t >= 1) begin
            int s;
            logic [7:0] v;
            s = t - 1;
            v = 8'hA5;
            if (s <= 5 || s == 14) check("R6", pix_out, 4'd0, underflow, 1'b1);
            else                   check("R6", pix_out, {3'b000, v[7-(s-6)]}, underflow, 1'b0);
         end
         line_start = (t == -1);
         pix_en     = (t >= 0 && t <= 14);
         byte_valid = (t == 5); byte_is_attr = 1'b0; byte_data = 8'hA5;
      end
      @(negedge clk);
      check("R3 idle", pix_out, 4'd0, underflow, 1'b0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1;
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule